// File: doc/BRIEF.md
# External Interrupt Enable and Trigger Logic

This block is the interrupt front end of a small controller. Two active-low external request pins are brought into the clock domain through a two-flop synchroniser. Each pin can be set to one of two trigger modes: in level mode its pending flag tracks the pin, and in falling-edge mode the flag latches on a high-to-low transition. Two timer-overflow pulses set overflow flags, and a serial request pulse sets a serial pending bit.

Software programs two 8-bit registers through a simple write port: an enable register and a control register. Both read back continuously on output buses. Every pending source is gated by its own enable bit and by a master enable. The surviving request with the highest fixed priority is presented as a request line and a vector address. An acknowledge clears the flag of the source being presented, as long as that flag is a latched one.

Top module: `irq_gate`

## Requirements
- R1: After reset both registers read 0, `irq_req` is 0 and `irq_vec` is 0. All sources are disabled and both pins are in level mode.
- R2: The enable register bits are: bit 0 ext0, bit 1 timer0, bit 2 ext1, bit 3 timer1, bit 4 serial, bit 5 an extra stored timer bit with no source, bit 6 reserved (always reads 0), and bit 7 master enable. Writing FFh reads back BFh.
- R3: While the master enable (bit 7) is 0, `irq_req` stays 0 whatever the individual enables and pending flags hold.
- R4: With the master enable set, a pending source whose own enable bit is 0 is not requested. Writing 89h passes only ext0 and timer1.
- R5: The control register bits are: bit 0 ext0 type, bit 1 ext0 flag, bit 2 ext1 type, bit 3 ext1 flag, bit 4 timer0 run, bit 5 timer0 overflow flag, bit 6 timer1 run, and bit 7 timer1 overflow flag. A write loads all eight bits. When a type bit is 0, the flag follows the inverted synchronised pin, and an acknowledge does not clear it.
- R6: When a type bit is 1, the flag sets on a synchronised 1-to-0 transition. It stays set after the pin returns high and clears on acknowledge. A pin that is held low does not set the flag again.
- R7: A pin change reaches its flag on the third rising clock edge after the pin changes, and not on the second.
- R8: A one-cycle `tmr_ovf[k]` pulse sets timer k's overflow flag on the next edge, and an acknowledge of its vector clears it.
- R9: A one-cycle `ser_req` pulse makes the serial source pending until its vector is acknowledged.
- R10: The fixed priority, from highest to lowest, is ext0 (0003h), timer0 (000Bh), ext1 (0013h), timer1 (001Bh) and serial (0023h). `irq_vec` carries the vector of the winning source.
- R11: An acknowledge clears only the source currently presented. An acknowledge given while no request is presented changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the enable register, 1 selects the control register |
| cfg_wdata | input | 8 | Write data |
| en_q | output | 8 | Enable register contents |
| ctl_q | output | 8 | Control register contents |
| ext_n | input | 2 | External request pins, active low |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ser_req | input | 1 | Serial request pulse |
| irq_ack | input | 1 | Acknowledge of the presented vector |
| irq_req | output | 1 | Request to the processor |
| irq_vec | output | VEC_W | Vector address of the winning source |

## Verification
The assertions check the following on every cycle:
- master-enable blocking;
- the legality of every presented vector;
- the holding of a latched edge flag;
- level tracking of the synchronised pin;
- the setting of overflow and serial flags.

Other behaviours can only be shown by the bench scenarios: the exact three-edge latency, no retrigger while a pin is held low, the priority walk across many pending sources as each is acknowledged, and the register readback layout.

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       en_q,
  output logic [7:0]       ctl_q,
  input  logic [1:0]       ext_n,
  input  logic [1:0]       tmr_ovf,
  input  logic             ser_req,
  input  logic             irq_ack,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);

  localparam int NSRC = 5;
  localparam logic [7:0] EN_MASK = 8'hBF;

  logic [7:0] en_r, ctl_r, ctl_nx;
  logic [1:0] sync_a, sync_b, prev;
  logic       ser_pend;
  logic [NSRC-1:0] gated, win_oh, ack_hit;
  logic [2:0] win;
  logic       wr_en, wr_ctl;

  assign wr_en  = cfg_we && !cfg_sel;
  assign wr_ctl = cfg_we &&  cfg_sel;
  assign en_q   = en_r;
  assign ctl_q  = ctl_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_a <= '1;
      sync_b <= '1;
      prev   <= '1;
    end else begin
      sync_a <= ext_n;
      sync_b <= sync_a;
      prev   <= sync_b;
    end

  assign gated = {ser_pend & en_r[4], ctl_r[7] & en_r[3], ctl_r[3] & en_r[2],
                  ctl_r[5] & en_r[1], ctl_r[1] & en_r[0]} & {NSRC{en_r[7]}};

  always_comb begin
    win    = '0;
    win_oh = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (gated[i]) begin
        win    = 3'(i);
        win_oh = NSRC'(1) << i;
      end
  end

  assign irq_req = |gated;
  assign irq_vec = irq_req ? VEC_W'(VEC_BASE + VEC_STEP * int'(win)) : '0;
  assign ack_hit = win_oh & {NSRC{irq_ack}};

  always_comb begin
    ctl_nx = ctl_r;
    for (int k = 0; k < 2; k++) begin
      if (ctl_r[2*k])
        ctl_nx[2*k+1] = (prev[k] & ~sync_b[k]) | (ctl_r[2*k+1] & ~ack_hit[2*k]);
      else
        ctl_nx[2*k+1] = ~sync_b[k];
    end
    ctl_nx[5] = tmr_ovf[0] | (ctl_r[5] & ~ack_hit[1]);
    ctl_nx[7] = tmr_ovf[1] | (ctl_r[7] & ~ack_hit[3]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_r     <= '0;
      ctl_r    <= '0;
      ser_pend <= 1'b0;
    end else begin
      if (wr_en) en_r <= cfg_wdata & EN_MASK;
      ctl_r    <= wr_ctl ? cfg_wdata : ctl_nx;
      ser_pend <= ser_req | (ser_pend & ~ack_hit[4]);
    end

  a_r3_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[7] |-> !irq_req);

  a_r10_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec == VEC_W'(16'h0003) || irq_vec == VEC_W'(16'h000B) ||
                 irq_vec == VEC_W'(16'h0013) || irq_vec == VEC_W'(16'h001B) ||
                 irq_vec == VEC_W'(16'h0023)));

  a_r6_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[0] && ctl_q[1] && !(irq_ack && irq_vec == VEC_W'(16'h0003)) && !wr_ctl)
      |=> ctl_q[1]);

  a_r5_level_track: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[2] && !wr_ctl) |=> (ctl_q[3] == !$past(sync_b[1])));

  a_r8_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_ovf[1] && !wr_ctl) |=> ctl_q[7]);

  a_r9_ser_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ser_req |=> ser_pend);

endmodule

// File: tb/tb_irq_gate.sv
module tb_irq_gate;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [7:0] cfg_wdata = 0;
  logic [7:0] en_q, ctl_q;
  logic [1:0] ext_n = 2'b11, tmr_ovf = 0;
  logic ser_req = 0, irq_ack = 0;
  logic irq_req;
  logic [15:0] irq_vec;

  typedef struct { int kind; logic [16:0] exp; string tag; } item_t;
  item_t exp_q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  irq_gate dut (.*);

  always #10 clk = ~clk;

  initial forever begin
    wait (exp_q.size() > 0);
    begin
      logic [16:0] act;
      case (exp_q[0].kind)
        0: act = {irq_req, irq_vec};
        1: act = {9'd0, en_q};
        default: act = {9'd0, ctl_q};
      endcase
      checks++;
      if (act !== exp_q[0].exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", exp_q[0].tag, act, exp_q[0].exp);
      end
      void'(exp_q.pop_front());
    end
  end

  task automatic expect_item(int kind, logic [16:0] e, string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    wait (exp_q.size() == 0);
  endtask

  task automatic chk_irq(logic r, logic [15:0] v, string tag); expect_item(0, {r, v}, tag); endtask
  task automatic chk_en(logic [7:0] v, string tag);  expect_item(1, {9'd0, v}, tag); endtask
  task automatic chk_ctl(logic [7:0] v, string tag); expect_item(2, {9'd0, v}, tag); endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic wr(logic sel, logic [7:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    tick(1);
    cfg_we = 0;
  endtask

  task automatic pulse_tmr(int k); tmr_ovf[k] = 1; tick(1); tmr_ovf = 0; endtask
  task automatic pulse_ser(); ser_req = 1; tick(1); ser_req = 0; endtask
  task automatic ack(); irq_ack = 1; tick(1); irq_ack = 0; endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    chk_en(8'h00, "R1 enable reset");
    chk_ctl(8'h00, "R1 control reset");
    chk_irq(0, 16'h0000, "R1 no request");

    wr(0, 8'hFF);
    chk_en(8'hBF, "R2 reserved bit reads 0");
    wr(0, 8'h00);

    pulse_tmr(0);
    chk_ctl(8'h20, "R8 timer0 flag set");
    chk_irq(0, 16'h0000, "R3 all disabled");
    wr(0, 8'h02);
    chk_irq(0, 16'h0000, "R3 master off blocks timer0");
    wr(0, 8'h82);
    chk_irq(1, 16'h000B, "R8 timer0 request");
    ack();
    chk_ctl(8'h00, "R8 ack clears timer0 flag");
    chk_irq(0, 16'h0000, "R8 no request after ack");

    wr(0, 8'h89);
    pulse_tmr(0);
    pulse_ser();
    chk_irq(0, 16'h0000, "R4 disabled sources not requested");
    chk_ctl(8'h20, "R4 timer0 still pending");
    pulse_tmr(1);
    chk_irq(1, 16'h001B, "R4 timer1 enabled by 89h");
    ack();
    chk_irq(0, 16'h0000, "R4 timer1 acked");
    wr(0, 8'h92);
    chk_irq(1, 16'h000B, "R10 timer0 above serial");
    ack();
    chk_irq(1, 16'h0023, "R9 serial pending");
    ack();
    chk_irq(0, 16'h0000, "R9 serial cleared");
    ack();
    chk_ctl(8'h00, "R11 idle ack no effect");
    chk_irq(0, 16'h0000, "R11 idle ack no request");

    wr(0, 8'h81);
    ext_n[0] = 0;
    tick(2);
    chk_irq(0, 16'h0000, "R7 not after two edges");
    tick(1);
    chk_irq(1, 16'h0003, "R7 level flag after three edges");
    ack();
    chk_irq(1, 16'h0003, "R5 level flag survives ack");
    ext_n[0] = 1;
    tick(3);
    chk_irq(0, 16'h0000, "R5 level flag follows pin high");

    wr(0, 8'h84);
    wr(1, 8'h04);
    ext_n[1] = 0;
    tick(3);
    chk_irq(1, 16'h0013, "R6 falling edge sets ext1");
    chk_ctl(8'h0C, "R5 ext1 flag bit position");
    ext_n[1] = 1;
    tick(4);
    chk_irq(1, 16'h0013, "R6 edge flag latched");
    ack();
    chk_irq(0, 16'h0000, "R6 ack clears edge flag");
    ext_n[1] = 0;
    tick(3);
    chk_irq(1, 16'h0013, "R6 second edge");
    ack();
    chk_irq(0, 16'h0000, "R6 cleared while held low");
    tick(4);
    chk_irq(0, 16'h0000, "R6 no retrigger while low");
    ext_n[1] = 1;
    tick(3);

    wr(0, 8'h9F);
    pulse_ser();
    pulse_tmr(1);
    chk_irq(1, 16'h001B, "R10 timer1 above serial");
    chk_ctl(8'h84, "R5 control with timer1 flag");
    ext_n[1] = 0;
    tick(3);
    chk_irq(1, 16'h0013, "R10 ext1 above timer1");
    ext_n[0] = 0;
    tick(3);
    chk_irq(1, 16'h0003, "R10 ext0 highest");
    ack();
    chk_irq(1, 16'h0003, "R10 level ext0 held");
    ext_n[0] = 1;
    tick(3);
    chk_irq(1, 16'h0013, "R10 ext1 next");
    ack();
    chk_irq(1, 16'h001B, "R11 only ext1 cleared");
    ack();
    chk_irq(1, 16'h0023, "R11 only timer1 cleared");
    ack();
    chk_irq(0, 16'h0000, "R9 serial acked");
    ext_n[1] = 1;
    tick(3);
    chk_irq(0, 16'h0000, "R6 rising edge no set");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule